// File: doc/BRIEF.md
# Coprocessor Instruction Queue Tracker

A coprocessor that shares a bus with a host processor cannot read the host's prefetch queue directly. It has to rebuild the instruction stream from two sources. The first is the code bytes it sees travelling over the bus during host fetch cycles. The second is a 2-bit queue-status code that the host drives each cycle. This block keeps a mirror of the host queue. Each completed code-fetch data phase appends its bytes to the mirror, lowest byte lane first. Each queue-status code then tells the block whether the host took a byte out, and whether that byte started an instruction, or whether the host discarded its whole queue.

A small decoder state machine watches the bytes as they leave the mirror. It claims only escape-class opcodes, which are first bytes whose top five bits are `11011`. The byte that follows such an opcode is captured as the ModRM byte. The block then raises a one-cycle strobe together with the opcode and ModRM pair. The decoder drops every other opcode and the bytes that follow it. The mirror depth is a parameter: 6 bytes for a 2-byte bus and 4 bytes for a 1-byte bus. A sticky flag records any fetched byte that found no room in the mirror.

Decoder states and transitions:
- States are `DEC_IDLE` (waiting for a first byte) and `DEC_NEED_MODRM` (an escape opcode is held).
- ESC_SEEN: `DEC_IDLE` goes to `DEC_NEED_MODRM` when a first byte is an escape.
- NON_ESC_DROP: `DEC_IDLE` stays in `DEC_IDLE` when a first byte is not an escape.
- MODRM_TAKEN: `DEC_NEED_MODRM` goes to `DEC_IDLE` on a subsequent byte, and the strobe fires.
- ABANDON: `DEC_NEED_MODRM` goes to `DEC_IDLE` on a first byte that is not an escape.
- RE_ESC: `DEC_NEED_MODRM` stays in `DEC_NEED_MODRM` on a first byte that is an escape, and the new opcode replaces the held one.
- FLUSHED: any state goes to `DEC_IDLE` on the flush code.

Top module: `copro_queue_tracker`

## Requirements
- R1: After reset, `esc_valid`, `overflow`, `esc_opcode` and `esc_modrm` are all 0, and the mirror is empty.
- R2: A byte is appended to the mirror at a rising edge where both `fetch_valid` and `bus_ready` are 1. Bus lane 0 (bits 7:0) is appended first, then the higher lanes in order. When `bus_ready` is 0, nothing is appended.
- R3: The queue-status codes 01 and 11 each remove the oldest byte from the mirror. Code 01 marks that byte as the first byte of an instruction. Code 11 marks it as a subsequent byte.
- R4: Suppose a byte removed under code 01 matches `11011xxx`, and the next byte removed is removed under code 11. Then `esc_valid` is 1 for exactly one cycle, after the edge on which the second byte is removed. During that cycle `esc_opcode` carries the first byte and `esc_modrm` carries the second. Both outputs hold their values until the next strobe.
- R5: A first byte that does not match `11011xxx` is dropped, and no subsequent byte that follows it raises `esc_valid`.
- R6: A code 01 removal that arrives while a ModRM byte is awaited discards the held opcode. The new first byte is then decoded in place of the old one.
- R7: Code 10 empties the mirror, discards any held opcode, clears `overflow`, and discards any fetch in the same cycle.
- R8: A fetched byte that finds the mirror full, counting the removal made in the same cycle, is discarded. The byte also sets `overflow`, which stays 1 until a flush or reset.
- R9: A code 01 or 11 that arrives while the mirror is empty changes no state.
- R10: Code 00 leaves the mirror and the decoder unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| fetch_valid | input | 1 | Host bus is in the data phase of a code fetch |
| bus_ready | input | 1 | Data phase completes this cycle |
| fetch_data | input | 8*BUS_BYTES | Code bytes on the bus; lane 0 is the oldest |
| queue_status | input | 2 | Host queue operation: 00 none, 01 first byte, 10 flush, 11 subsequent byte |
| esc_valid | output | 1 | One-cycle strobe for a captured escape instruction |
| esc_opcode | output | 8 | Escape opcode of the last capture |
| esc_modrm | output | 8 | ModRM byte of the last capture |
| overflow | output | 1 | Sticky flag: a fetched byte was discarded because the mirror was full |

## Verification
Every result in this block becomes visible one rising edge after the stimulus that causes it. The escape strobe and its opcode/ModRM pair appear after the edge that samples the code-11 removal. The overflow flag appears after the edge that samples the fetch that found no room. A flush takes effect at the edge that samples code 10. The bench applies each cycle's inputs on the falling edge and advances its reference model at the next rising edge. It then compares all outputs on the falling edge that follows, one edge after the cause, as the requirements give. Randomised queue traffic rich in escape bytes and rare flushes runs alongside directed cases for lane order, stalled fetches, abandonment, removal from an empty mirror and overflow.

// File: rtl/cqt_pkg.sv
package cqt_pkg;

    typedef enum logic [1:0] {
        QS_NONE  = 2'b00,
        QS_FIRST = 2'b01,
        QS_FLUSH = 2'b10,
        QS_NEXT  = 2'b11
    } qs_e;

    typedef enum logic {
        DEC_IDLE,
        DEC_NEED_MODRM
    } dec_state_e;

    localparam logic [4:0] ESC_PREFIX = 5'b11011;

    function automatic logic is_escape(input logic [7:0] b);
        return b[7:3] == ESC_PREFIX;
    endfunction

endpackage

// File: rtl/cqt_mirror.sv
module cqt_mirror #(
    parameter int BUS_BYTES = 2,
    parameter int DEPTH     = 6
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   flush,
    input  logic                   push_en,
    input  logic [8*BUS_BYTES-1:0] push_data,
    input  logic                   pop_req,
    output logic                   head_valid,
    output logic [7:0]             head_byte,
    output logic                   drop
);
    localparam int CW = $clog2(DEPTH + 1);

    logic [7:0]    q     [DEPTH];
    logic [7:0]    nxt_q [DEPTH];
    logic [CW-1:0] cnt;
    logic [CW-1:0] nxt_cnt;
    int            fill;

    // Shift-register queue: slot 0 always holds the oldest byte.
    always_comb begin
        nxt_q = q;
        fill  = int'(cnt);
        drop  = 1'b0;
        if (pop_req && cnt != '0) begin
            for (int s = 0; s < DEPTH - 1; s++) begin
                nxt_q[s] = q[s+1];
            end
            fill = fill - 1;
        end
        if (push_en) begin
            for (int b = 0; b < BUS_BYTES; b++) begin
                if (fill < DEPTH) begin
                    for (int s = 0; s < DEPTH; s++) begin
                        if (s == fill) begin
                            nxt_q[s] = push_data[8*b +: 8];
                        end
                    end
                    fill = fill + 1;
                end else begin
                    drop = 1'b1;
                end
            end
        end
        nxt_cnt = CW'(fill);
    end

    always_ff @(posedge clk) begin
        if (!rst_n || flush) begin
            cnt <= '0;
            for (int s = 0; s < DEPTH; s++) begin
                q[s] <= 8'h00;
            end
        end else begin
            cnt <= nxt_cnt;
            q   <= nxt_q;
        end
    end

    assign head_valid = (cnt != '0);
    assign head_byte  = q[0];

endmodule

// File: rtl/cqt_decoder.sv
module cqt_decoder
    import cqt_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  qs_e        qs,
    input  logic       head_valid,
    input  logic [7:0] head_byte,
    output logic       esc_valid,
    output logic [7:0] esc_opcode,
    output logic [7:0] esc_modrm
);
    dec_state_e state;
    dec_state_e nxt_state;
    logic [7:0] opc_hold;
    logic       take_first;
    logic       take_next;

    assign take_first = head_valid && (qs == QS_FIRST);
    assign take_next  = head_valid && (qs == QS_NEXT);

    // Transition logic
    always_comb begin
        nxt_state = state;
        unique case (state)
            DEC_IDLE: begin
                if (take_first && is_escape(head_byte)) begin
                    nxt_state = DEC_NEED_MODRM;              // ESC_SEEN
                end                                           // else NON_ESC_DROP
            end
            DEC_NEED_MODRM: begin
                if (take_next) begin
                    nxt_state = DEC_IDLE;                    // MODRM_TAKEN
                end else if (take_first) begin
                    nxt_state = is_escape(head_byte) ? DEC_NEED_MODRM   // RE_ESC
                                                     : DEC_IDLE;        // ABANDON
                end
            end
        endcase
        if (qs == QS_FLUSH) begin
            nxt_state = DEC_IDLE;                            // FLUSHED
        end
    end

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= DEC_IDLE;
        end else begin
            state <= nxt_state;
        end
    end

    // Output registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            esc_valid  <= 1'b0;
            esc_opcode <= 8'h00;
            esc_modrm  <= 8'h00;
            opc_hold   <= 8'h00;
        end else begin
            esc_valid <= 1'b0;
            if (take_first && is_escape(head_byte)) begin
                opc_hold <= head_byte;
            end
            if (state == DEC_NEED_MODRM && take_next) begin
                esc_valid  <= 1'b1;
                esc_opcode <= opc_hold;
                esc_modrm  <= head_byte;
            end
        end
    end

endmodule

// File: rtl/copro_queue_tracker.sv
module copro_queue_tracker
    import cqt_pkg::*;
#(
    parameter int BUS_BYTES = 2,
    parameter int DEPTH     = (BUS_BYTES == 1) ? 4 : 6
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   fetch_valid,
    input  logic                   bus_ready,
    input  logic [8*BUS_BYTES-1:0] fetch_data,
    input  logic [1:0]             queue_status,
    output logic                   esc_valid,
    output logic [7:0]             esc_opcode,
    output logic [7:0]             esc_modrm,
    output logic                   overflow
);
    qs_e        qs;
    logic       flush;
    logic       push_en;
    logic       pop_req;
    logic       head_valid;
    logic [7:0] head_byte;
    logic       drop;

    assign qs      = qs_e'(queue_status);
    assign flush   = (qs == QS_FLUSH);
    assign push_en = fetch_valid && bus_ready && !flush;
    assign pop_req = (qs == QS_FIRST) || (qs == QS_NEXT);

    cqt_mirror #(
        .BUS_BYTES (BUS_BYTES),
        .DEPTH     (DEPTH)
    ) u_mirror (
        .clk        (clk),
        .rst_n      (rst_n),
        .flush      (flush),
        .push_en    (push_en),
        .push_data  (fetch_data),
        .pop_req    (pop_req),
        .head_valid (head_valid),
        .head_byte  (head_byte),
        .drop       (drop)
    );

    cqt_decoder u_dec (
        .clk        (clk),
        .rst_n      (rst_n),
        .qs         (qs),
        .head_valid (head_valid),
        .head_byte  (head_byte),
        .esc_valid  (esc_valid),
        .esc_opcode (esc_opcode),
        .esc_modrm  (esc_modrm)
    );

    always_ff @(posedge clk) begin
        if (!rst_n || flush) begin
            overflow <= 1'b0;
        end else if (drop) begin
            overflow <= 1'b1;
        end
    end

endmodule

// File: rtl/copro_queue_tracker_chk.sv
module copro_queue_tracker_chk (
    input logic       clk,
    input logic       rst_n,
    input logic [1:0] queue_status,
    input logic       esc_valid,
    input logic [7:0] esc_opcode,
    input logic       overflow
);
    AST_STROBE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        esc_valid |=> !esc_valid);                                          // R4
    AST_STROBE_ESCAPE: assert property (@(posedge clk) disable iff (!rst_n)
        esc_valid |-> esc_opcode[7:3] == 5'b11011);                          // R4
    AST_STROBE_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
        esc_valid |-> $past(queue_status) == 2'b11);                          // R4
    AST_FLUSH_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        queue_status == 2'b10 |=> !esc_valid && !overflow);                  // R7
    AST_OVF_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        overflow && queue_status != 2'b10 |=> overflow);                     // R8
    AST_IDLE_NO_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
        queue_status == 2'b00 |=> !esc_valid);                               // R10
endmodule

bind copro_queue_tracker copro_queue_tracker_chk u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .queue_status (queue_status),
    .esc_valid    (esc_valid),
    .esc_opcode   (esc_opcode),
    .overflow     (overflow)
);

// File: tb/copro_queue_tracker_test.sv
module copro_queue_tracker_test;
    localparam int CLK_PERIOD = 10;
    localparam int BUS_BYTES  = 2;
    localparam int DEPTH      = 6;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        fetch_valid = 1'b0;
    logic        bus_ready = 1'b0;
    logic [15:0] fetch_data = 16'h0000;
    logic [1:0]  queue_status = 2'b00;
    logic        esc_valid;
    logic [7:0]  esc_opcode;
    logic [7:0]  esc_modrm;
    logic        overflow;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    // Reference model state
    logic [7:0] m_q [8];
    int         m_n = 0;
    bit         m_wait = 0;
    logic [7:0] m_op = 0;
    bit         m_valid = 0;
    logic [7:0] m_opc = 0;
    logic [7:0] m_mod = 0;
    bit         m_ovf = 0;

    copro_queue_tracker #(.BUS_BYTES(BUS_BYTES), .DEPTH(DEPTH)) uut (
        .clk(clk), .rst_n(rst_n), .fetch_valid(fetch_valid), .bus_ready(bus_ready),
        .fetch_data(fetch_data), .queue_status(queue_status), .esc_valid(esc_valid),
        .esc_opcode(esc_opcode), .esc_modrm(esc_modrm), .overflow(overflow)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    function automatic bit esc_byte(input logic [7:0] b);
        return b[7:3] == 5'b11011;
    endfunction

    function automatic logic [7:0] rand_byte();
        logic [7:0] b;
        b = 8'($urandom);
        if ($urandom_range(1, 0) == 1) b[7:3] = 5'b11011;
        return b;
    endfunction

    task automatic model_edge();
        logic [7:0] b;
        bit popped;
        m_valid = 0;
        if (queue_status == 2'b10) begin
            m_n = 0; m_wait = 0; m_ovf = 0;
            return;
        end
        popped = (queue_status == 2'b01 || queue_status == 2'b11) && m_n > 0;
        b = m_q[0];
        if (popped) begin
            for (int i = 0; i < 7; i++) m_q[i] = m_q[i+1];
            m_n--;
            if (queue_status == 2'b01) begin
                m_wait = esc_byte(b);
                if (m_wait) m_op = b;
            end else if (m_wait) begin
                m_valid = 1; m_opc = m_op; m_mod = b; m_wait = 0;
            end
        end
        if (fetch_valid && bus_ready) begin
            for (int k = 0; k < BUS_BYTES; k++) begin
                if (m_n < DEPTH) begin
                    m_q[m_n] = fetch_data[8*k +: 8];
                    m_n++;
                end else begin
                    m_ovf = 1;
                end
            end
        end
    endtask

    task automatic compare(input string tag);
        checks++;
        if (esc_valid !== m_valid || esc_opcode !== m_opc ||
            esc_modrm !== m_mod || overflow !== m_ovf) begin
            fails++;
            $display("FAIL %s: actual v=%0b op=%02h mr=%02h ovf=%0b expected v=%0b op=%02h mr=%02h ovf=%0b",
                     tag, esc_valid, esc_opcode, esc_modrm, overflow,
                     m_valid, m_opc, m_mod, m_ovf);
        end
    endtask

    // One cycle: drive on falling edge, model at rising edge, check on next falling edge.
    task automatic step(input bit fv, input bit rdy, input logic [15:0] d,
                        input logic [1:0] qs, input string tag);
        fetch_valid = fv; bus_ready = rdy; fetch_data = d; queue_status = qs;
        @(posedge clk);
        model_edge();
        @(negedge clk);
        compare(tag);
    endtask

    task automatic push(input logic [15:0] d, input string tag);
        step(1, 1, d, 2'b00, tag);
    endtask

    task automatic qop(input logic [1:0] qs, input string tag);
        step(0, 0, 16'h0000, qs, tag);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            fails++;
            $display("FAIL R1 watchdog: actual=running expected=finished");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd1234));
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        compare("R1 reset state");
        qop(2'b01, "R9 first-byte code on empty mirror");
        qop(2'b11, "R9 subsequent-byte code on empty mirror");
        // R2: lane 0 is removed first
        push(16'h05D8, "R2 push escape pair");
        qop(2'b01, "R3 take escape opcode");
        qop(2'b11, "R4 take modrm, strobe");
        qop(2'b00, "R4 strobe lasts one cycle");
        // R2: stalled data phase appends nothing
        step(1, 0, 16'h11DC, 2'b00, "R2 not ready");
        qop(2'b01, "R2 nothing appended while not ready");
        qop(2'b11, "R2 nothing appended while not ready");
        // R5: non-escape dropped
        push(16'hD990, "R5 push non-escape");
        qop(2'b01, "R5 non-escape first byte");
        qop(2'b11, "R5 no strobe after non-escape");
        // R6: abandon a held opcode
        push(16'hDBDA, "R6 push two escapes");
        qop(2'b01, "R6 first escape held");
        qop(2'b01, "R6 second escape replaces");
        push(16'h0077, "R6 push modrm");
        qop(2'b11, "R6 strobe carries replacing opcode");
        qop(2'b11, "R6 trailing byte ignored");
        // R10: idle holds
        qop(2'b00, "R10 idle");
        qop(2'b00, "R10 idle");
        // R7: flush drops held opcode and same-cycle fetch
        push(16'h33DE, "R7 push");
        qop(2'b01, "R7 escape held");
        step(1, 1, 16'h4444, 2'b10, "R7 flush with fetch");
        qop(2'b11, "R7 flushed mirror is empty");
        // R8: overflow
        for (int i = 0; i < 4; i++) push(16'hD8D8, "R8 fill past depth");
        qop(2'b00, "R8 overflow sticky");
        qop(2'b01, "R8 overflow holds across removal");
        qop(2'b10, "R7 flush clears overflow");
        // R8 boundary: removal in the same cycle frees a slot
        for (int i = 0; i < 3; i++) push(16'h01D9, "R8 fill to depth");
        step(1, 1, 16'h0203, 2'b01, "R8 push with pop at full");
        qop(2'b10, "R7 flush");
        // Random traffic
        for (int i = 0; i < 4000; i++) begin
            logic [1:0] qs;
            int r;
            r = $urandom_range(15, 0);
            qs = (r == 0) ? 2'b10 : (r < 5) ? 2'b00 : (r < 10) ? 2'b01 : 2'b11;
            step($urandom_range(1, 0) == 1, $urandom_range(3, 0) != 0,
                 {rand_byte(), rand_byte()}, qs, "R4 random traffic");
        end
        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule